// File: doc/BRIEF.md
# Programmable Interval Timer Channel

This block is one channel of a programmable interval timer. It holds a 16-bit down-counter that is driven by an external count-clock enable, nominally 1,193,182 Hz, which comes as a one-cycle strobe from the much faster system clock. Software talks to the channel through a byte-wide register interface. A port-select bit picks between a control port and a data port. Control writes program the operating mode. Data writes load the count as two bytes. A read-back command captures a status byte that the next data-port read returns.

The channel has two operating modes. The first is an interrupt on terminal count: the output pin rises when the count runs out and stays high. The second is a software-triggered single strobe: the output pin stays high and drops for exactly one count-clock period when the count runs out. Each of these output events also raises a one-system-clock interrupt request pulse. Writing a control word stops the channel until a full new count has been written. A loaded value of zero stands for 65536.

Top module: `interval_timer`

## Requirements
- R1: After reset, tmr_out and irq are low, no mode is configured, the read-back status is 0x00, and data-port writes and count-clock enables have no effect until a valid mode word is written.
- R2: A control-port byte is a mode word only when bits 7:6 = 00, bits 5:4 = 11, bit 0 = 0 and bits 3:1 = 000 (terminal-count mode) or 100 (strobe mode). Any other byte whose bits 7:6 are not 11 is ignored and leaves the status and the output unchanged.
- R3: The count is written to the data port low byte first, then high byte. A low-byte write alone starts nothing. The value is transferred into the counter on the first count-clock enable in a cycle after the high-byte write, and each later enable decrements it by one.
- R4: In terminal-count mode, a mode word or a completed count write drives tmr_out low. tmr_out rises on the N-th enable after the transferring enable (N = loaded value) and then stays high while enables continue.
- R5: In strobe mode, a mode word drives tmr_out high. On the N-th enable after the transfer, tmr_out goes low for exactly one enable period, then returns high and stays high.
- R6: A loaded count of 0 counts 65536 enables before expiring.
- R7: Writing a mode word while counting stops the countdown. No further output event occurs until a new count has been written and transferred.
- R8: A control byte with bits 7:6 = 11, bit 4 = 0 and bit 1 = 1 (for example 0xE2) latches the status byte: bit 7 = tmr_out, bit 6 = null-count flag, bits 5:4 = access field, bits 3:1 = mode, bit 0 = 0. The next data-port read returns it. Data-port reads return 0x00 when no status is latched, and a read consumes the latched value.
- R9: The null-count flag sets when the high byte of a count is written and clears when that count is transferred into the counter.
- R10: irq is a one-system-clock pulse, raised in the same cycle as the rising edge of tmr_out in terminal-count mode and the falling edge of tmr_out in strobe mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Count-clock enable, one system cycle per count tick |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| port_sel | input | 1 | 1 selects the control port, 0 the data port |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data byte (latched status or 0x00) |
| tmr_out | output | 1 | Timer output pin |
| irq | output | 1 | One-cycle interrupt request pulse |

## Verification
The terminal-count mode is run with a count of 5, with 0x0102 and with 0, and then again after the count is rewritten. With 0x0102, low-first and high-first byte order give different expiry times (258 against 513 enables). The value 0 separates a proper 65536-count wrap from an immediate expiry. The strobe mode is run with a count of 3, which shows that the low pulse lasts one enable and does not repeat. Stopping mid-count, words that must be ignored, and writes issued before any mode is set are judged through the output pin, the interrupt pulse count and the read-back status byte.

// File: rtl/itmr_pkg.sv
package itmr_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;

    typedef enum logic [2:0] {
        MODE_TERM   = 3'd0,
        MODE_STROBE = 3'd4
    } tmode_e;

    localparam logic [1:0] SEL_CH0  = 2'b00;
    localparam logic [1:0] SEL_RDBK = 2'b11;
    localparam logic [1:0] ACC_LOHI = 2'b11;

    typedef struct packed {
        logic [1:0] sel;
        logic [1:0] acc;
        logic [2:0] mode;
        logic       bcd;
    } ctl_word_t;

    typedef struct packed {
        logic       out;
        logic       nul;
        logic [1:0] acc;
        logic [2:0] mode;
        logic       bcd;
    } status_t;

    typedef enum logic [1:0] {
        CW_IGNORE,
        CW_MODE,
        CW_RDBK
    } cw_kind_e;

    function automatic cw_kind_e classify(input ctl_word_t w);
        if (w.sel == SEL_RDBK)
            return CW_RDBK;
        if (w.sel == SEL_CH0 && w.acc == ACC_LOHI && !w.bcd &&
            (w.mode == MODE_TERM || w.mode == MODE_STROBE))
            return CW_MODE;
        return CW_IGNORE;
    endfunction

    // read-back byte: bit 4 low asks for status, bit 1 picks the channel
    function automatic logic wants_status(input logic [BYTE_W-1:0] b);
        return !b[4] && b[1];
    endfunction

endpackage

// File: rtl/itmr_ctrl.sv
module itmr_ctrl
    import itmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              port_sel,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              out_lvl,
    input  logic              null_flag,
    output logic [BYTE_W-1:0] rdata,
    output logic              cfg_wr,
    output tmode_e            cfg_mode,
    output tmode_e            cur_mode,
    output logic              halt,
    output logic              cnt_wr,
    output logic [CNT_W-1:0]  cnt_val
);

    ctl_word_t        cw;
    cw_kind_e         kind;
    logic             is_ctl, is_dat, dat_ok, rdbk_hit;
    tmode_e           mode_q;
    logic [1:0]       acc_q;
    logic             hi_next;
    logic [BYTE_W-1:0] lo_q;
    status_t          stat_q;
    logic             stat_vld;

    always_comb begin
        cw       = ctl_word_t'(wdata);
        kind     = classify(cw);
        is_ctl   = wr_en && port_sel;
        is_dat   = wr_en && !port_sel;
        cfg_wr   = is_ctl && (kind == CW_MODE);
        cfg_mode = tmode_e'(cw.mode);
        rdbk_hit = is_ctl && (kind == CW_RDBK) && wants_status(wdata);
        dat_ok   = is_dat && (acc_q == ACC_LOHI);
        halt     = dat_ok && !hi_next;
        cnt_wr   = dat_ok && hi_next;
        cnt_val  = {wdata, lo_q};
        cur_mode = mode_q;
        rdata    = stat_vld ? BYTE_W'(stat_q) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= MODE_TERM;
            acc_q    <= 2'b00;
            hi_next  <= 1'b0;
            lo_q     <= '0;
            stat_q   <= '0;
            stat_vld <= 1'b0;
        end else begin
            if (cfg_wr) begin
                mode_q  <= cfg_mode;
                acc_q   <= cw.acc;
                hi_next <= 1'b0;
            end
            if (halt) begin
                lo_q    <= wdata;
                hi_next <= 1'b1;
            end
            if (cnt_wr)
                hi_next <= 1'b0;
            if (rdbk_hit) begin
                stat_q   <= '{out: out_lvl, nul: null_flag, acc: acc_q,
                              mode: mode_q, bcd: 1'b0};
                stat_vld <= 1'b1;
            end else if (rd_en && !port_sel) begin
                stat_vld <= 1'b0;
            end
        end
    end

    AST_READ_CONSUMES: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !port_sel && !wr_en) |=> (rdata == '0)) else $error("read did not consume status"); // R8

    AST_IGNORED_KEEPS_MODE: assert property (@(posedge clk) disable iff (rst)
        (is_ctl && kind == CW_IGNORE) |=> $stable(cur_mode)) else $error("ignored word changed mode"); // R2

endmodule

// File: rtl/itmr_counter.sv
module itmr_counter
    import itmr_pkg::*;
#(
    parameter int WIDTH = CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_en,
    input  logic             cfg_wr,
    input  tmode_e           cfg_mode,
    input  tmode_e           cur_mode,
    input  logic             halt,
    input  logic             cnt_wr,
    input  logic [WIDTH-1:0] cnt_val,
    output logic             out_lvl,
    output logic             null_flag,
    output logic             irq
);

    logic [WIDTH-1:0] cr_q, ce_q;
    logic             armed, load_pend, strobe, out_q, nul_q, irq_q;
    logic             quiet;

    always_comb begin
        quiet     = !cfg_wr && !cnt_wr && !halt;
        out_lvl   = out_q;
        null_flag = nul_q;
        irq       = irq_q;
    end

    // A loaded 0 wraps through all ones, so it expires after 2**WIDTH steps.
    always_ff @(posedge clk) begin
        if (rst) begin
            cr_q      <= '0;
            ce_q      <= '0;
            armed     <= 1'b0;
            load_pend <= 1'b0;
            strobe    <= 1'b0;
            out_q     <= 1'b0;
            nul_q     <= 1'b0;
            irq_q     <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            if (cfg_wr) begin
                armed     <= 1'b0;
                load_pend <= 1'b0;
                strobe    <= 1'b0;
                nul_q     <= 1'b0;
                out_q     <= (cfg_mode == MODE_STROBE);
            end else if (halt) begin
                armed <= 1'b0;
            end else if (cnt_wr) begin
                cr_q      <= cnt_val;
                load_pend <= 1'b1;
                nul_q     <= 1'b1;
                armed     <= 1'b0;
                strobe    <= 1'b0;
                out_q     <= (cur_mode == MODE_STROBE);
            end else if (cnt_en) begin
                if (load_pend) begin
                    ce_q      <= cr_q;
                    load_pend <= 1'b0;
                    nul_q     <= 1'b0;
                    armed     <= 1'b1;
                end else if (armed) begin
                    ce_q <= ce_q - 1'b1;
                    if (ce_q == WIDTH'(1)) begin
                        armed <= 1'b0;
                        irq_q <= 1'b1;
                        if (cur_mode == MODE_STROBE) begin
                            out_q  <= 1'b0;
                            strobe <= 1'b1;
                        end else begin
                            out_q <= 1'b1;
                        end
                    end
                end else if (strobe) begin
                    strobe <= 1'b0;
                    out_q  <= 1'b1;
                end
            end
        end
    end

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
        irq_q |=> !irq_q) else $error("irq wider than one cycle"); // R10

    AST_TERM_RISE_IRQ: assert property (@(posedge clk) disable iff (rst)
        (cur_mode == MODE_TERM && $rose(out_q)) |-> irq_q) else $error("rise without irq"); // R10

    AST_STROBE_WIDTH: assert property (@(posedge clk) disable iff (rst)
        (cur_mode == MODE_STROBE && !out_q && cnt_en && quiet) |=> out_q) else $error("strobe too long"); // R5

    AST_NULL_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (nul_q && cnt_en && quiet) |=> !nul_q) else $error("null count stuck"); // R9

    AST_NULL_SET: assert property (@(posedge clk) disable iff (rst)
        cnt_wr |=> nul_q) else $error("null count not set"); // R9

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        (!cnt_en && quiet) |=> $stable(out_q)) else $error("output moved without tick"); // R3

endmodule

// File: rtl/interval_timer.sv
module interval_timer
    import itmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cnt_en,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              port_sel,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    output logic              tmr_out,
    output logic              irq
);

    logic             cfg_wr, halt, cnt_wr, out_lvl, null_flag;
    tmode_e           cfg_mode, cur_mode;
    logic [CNT_W-1:0] cnt_val;

    itmr_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .port_sel  (port_sel),
        .wdata     (wdata),
        .out_lvl   (out_lvl),
        .null_flag (null_flag),
        .rdata     (rdata),
        .cfg_wr    (cfg_wr),
        .cfg_mode  (cfg_mode),
        .cur_mode  (cur_mode),
        .halt      (halt),
        .cnt_wr    (cnt_wr),
        .cnt_val   (cnt_val)
    );

    itmr_counter #(.WIDTH(CNT_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .cnt_en    (cnt_en),
        .cfg_wr    (cfg_wr),
        .cfg_mode  (cfg_mode),
        .cur_mode  (cur_mode),
        .halt      (halt),
        .cnt_wr    (cnt_wr),
        .cnt_val   (cnt_val),
        .out_lvl   (out_lvl),
        .null_flag (null_flag),
        .irq       (irq)
    );

    assign tmr_out = out_lvl;

    AST_RESET_IDLE: assert property (@(posedge clk)
        $past(rst) |-> (!tmr_out && !irq)) else $error("not idle after reset"); // R1

endmodule

// File: tb/test_interval_timer.sv
`timescale 1ns/1ps
module test_interval_timer;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cnt_en = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic       port_sel = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       tmr_out, irq;

    int checks = 0;
    int fails  = 0;
    int irq_cnt = 0;
    bit done = 0;

    interval_timer i_interval_timer (
        .clk(clk), .rst(rst), .cnt_en(cnt_en), .wr_en(wr_en), .rd_en(rd_en),
        .port_sel(port_sel), .wdata(wdata), .rdata(rdata),
        .tmr_out(tmr_out), .irq(irq)
    );

    always #10 clk = ~clk;

    always @(posedge clk) if (!rst && irq) irq_cnt <= irq_cnt + 1;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] b);
        @(negedge clk);
        wr_en = 1'b1; port_sel = sel; wdata = b;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(output logic [7:0] v);
        @(negedge clk);
        rd_en = 1'b1; port_sel = 1'b0;
        #1 v = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic status(output logic [7:0] v);
        wr(1'b1, 8'hE2);
        rd(v);
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); cnt_en = 1'b1;
            @(negedge clk); cnt_en = 1'b0;
        end
    endtask

    task automatic tick_fast(input int n);
        @(negedge clk); cnt_en = 1'b1;
        repeat (n) @(negedge clk);
        cnt_en = 1'b0;
    endtask

    task automatic load(input logic [15:0] v);
        wr(1'b0, v[7:0]);
        wr(1'b0, v[15:8]);
    endtask

    task automatic t_reset;
        logic [7:0] s;
        chk("R1 out after reset", tmr_out, 0);
        chk("R1 irq after reset", irq, 0);
        rd(s);
        chk("R8 read with nothing latched", s, 8'h00);
        status(s);
        chk("R1 status after reset", s, 8'h00);
        load(16'h0002);
        tick(6);
        status(s);
        chk("R1 data writes ignored before mode", s, 8'h00);
        chk("R1 out stays low", tmr_out, 0);
    endtask

    task automatic t_mode0_basic;
        logic [7:0] s;
        int base;
        wr(1'b1, 8'h30);
        status(s);
        chk("R2 status after mode 0 word", s, 8'h30);
        wr(1'b0, 8'h05);
        tick(3);
        status(s);
        chk("R3 low byte alone starts nothing", s, 8'h30);
        wr(1'b0, 8'h00);
        status(s);
        chk("R9 null set after high byte", s, 8'h70);
        base = irq_cnt;
        tick(1);
        status(s);
        chk("R9 null cleared by transfer", s, 8'h30);
        tick(4);
        chk("R4 out low before expiry", tmr_out, 0);
        tick(1);
        chk("R4 out high at expiry", tmr_out, 1);
        chk("R10 irq with rising edge", irq, 1);
        tick(6);
        chk("R4 out stays high", tmr_out, 1);
        chk("R10 single irq in mode 0", irq_cnt - base, 1);
        status(s);
        chk("R8 status after expiry", s, 8'hB0);
        rd(s);
        chk("R8 second read returns zero", s, 8'h00);
        wr(1'b0, 8'h02);
        chk("R4 out held after low byte only", tmr_out, 1);
        wr(1'b0, 8'h00);
        chk("R4 new count drives out low", tmr_out, 0);
        tick(1);
        tick(1);
        chk("R4 reload count 2 not yet", tmr_out, 0);
        tick(1);
        chk("R4 reload count 2 expires", tmr_out, 1);
    endtask

    task automatic t_byte_order;
        wr(1'b1, 8'h30);
        load(16'h0102);
        tick(1);
        tick(257);
        chk("R3 byte order: 257 enables not expired", tmr_out, 0);
        tick(1);
        chk("R3 byte order: 258th enable expires", tmr_out, 1);
    endtask

    task automatic t_zero;
        wr(1'b1, 8'h30);
        load(16'h0000);
        tick(1);
        tick_fast(65535);
        chk("R6 zero count after 65535", tmr_out, 0);
        tick(1);
        chk("R6 zero count after 65536", tmr_out, 1);
    endtask

    task automatic t_strobe;
        logic [7:0] s;
        int base;
        wr(1'b1, 8'h38);
        chk("R5 mode word sets out high", tmr_out, 1);
        status(s);
        chk("R8 status after strobe word", s, 8'hB8);
        load(16'h0003);
        status(s);
        chk("R9 null in strobe mode", s, 8'hF8);
        base = irq_cnt;
        tick(1);
        tick(2);
        chk("R5 out high before expiry", tmr_out, 1);
        tick(1);
        chk("R5 out low at expiry", tmr_out, 0);
        chk("R10 irq at strobe", irq, 1);
        tick(1);
        chk("R5 out back high after one tick", tmr_out, 1);
        chk("R10 irq dropped", irq, 0);
        tick(5);
        chk("R5 out stays high", tmr_out, 1);
        chk("R10 single irq in strobe mode", irq_cnt - base, 1);
    endtask

    task automatic t_halt_ignore;
        logic [7:0] s;
        int base;
        wr(1'b1, 8'h30);
        load(16'd10);
        tick(1);
        tick(4);
        base = irq_cnt;
        wr(1'b1, 8'h30);
        tick(20);
        chk("R7 halted out stays low", tmr_out, 0);
        chk("R7 no irq after halt", irq_cnt - base, 0);
        status(s);
        chk("R7 halted status", s, 8'h30);
        wr(1'b1, 8'h70);
        wr(1'b1, 8'h32);
        wr(1'b1, 8'h31);
        wr(1'b1, 8'h10);
        wr(1'b1, 8'h38 | 8'h40);
        status(s);
        chk("R2 ignored words keep status", s, 8'h30);
        chk("R2 ignored words keep out", tmr_out, 0);
        wr(1'b1, 8'hF2);
        rd(s);
        chk("R8 read-back without status bit", s, 8'h00);
        load(16'd1);
        tick(1);
        tick(1);
        chk("R7 restart after new count", tmr_out, 1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_mode0_basic();
        t_byte_order();
        t_strobe();
        t_halt_ignore();
        t_zero();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule